// File: doc/BRIEF.md
# Successive-Approximation Converter Readout Sequencer

This block runs a fast successive-approximation converter that hands back each result one bit at a time. It works on a free-running system clock. It raises a conversion-start strobe for a fixed number of cycles and waits out the converter's data-ready delay. It then sends a burst of exactly one clock pulse per result bit. The returned serial bits are captured on the echoed clock that the converter sends back, never on the system clock. Once the burst has drained, the assembled word passes to the system domain as a signed sample with a one-cycle valid strobe.

Every timing rule is a parameter counted in system-clock cycles: start-pulse width, minimum spacing of starts, wait before the first bit, last-edge deadline, acquisition gap and settle time. Elaboration checks compare these counts against the converter's limits in nanoseconds. The data has no pipeline latency: the word delivered after a start strobe belongs to that same conversion. A generate option picks which echoed-clock edge captures the data.

Top module: `sar_readout`

## Requirements
- R1: While reset is held, `cnv_o`, `sclk_o` and `valid_o` are low and `sample_o` is zero. After release, the first start strobe rises no earlier than `CYC_MIN` cycles later.
- R2: Each start strobe stays high for exactly `CNV_HI` cycles. Elaboration rejects a count whose duration falls outside 10 to 40 ns.
- R3: Two rising edges of `cnv_o` are at least `CYC_MIN` cycles apart. A start is taken only in a cycle where `en_i` is high and the controller is idle.
- R4: The first rising edge of `sclk_o` comes exactly `MSB_WAIT` cycles after the rising edge of `cnv_o`.
- R5: Each conversion gets exactly `NBITS` clock pulses, each `CLK_HALF` cycles high and `CLK_HALF` cycles low. `sclk_o` is low at all other times, including while `cnv_o` is high.
- R6: The last rising edge of `sclk_o` lands `MSB_WAIT + 2*CLK_HALF*(NBITS-1)` cycles after the start. Elaboration rejects parameters that would put it past `LAST_CLK_MAX`.
- R7: Data bits on `d_i` are taken on the rising edge of `dco_i`, most significant bit first. The word is read as two's complement, so bit `NBITS-1` is the sign.
- R8: `valid_o` is high for exactly one cycle, `SYNC_WAIT` cycles after the last falling edge of `sclk_o`. `sample_o` then carries the word of the conversion just started and holds it until the next strobe.
- R9: The next rising edge of `cnv_o` comes at least `ACQ_MIN` cycles after the last falling edge of `sclk_o`.
- R10: No start is accepted between a rising edge of `cnv_o` and the cycle in which its `valid_o` strobe appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Allows new conversions to start |
| cnv_o | output | 1 | Conversion-start strobe to the converter |
| sclk_o | output | 1 | Bit clock burst to the converter, low when idle |
| dco_i | input | 1 | Echoed bit clock from the converter |
| d_i | input | 1 | Serial result bit, aligned to `dco_i` |
| sample_o | output | NBITS | Last captured result, signed |
| valid_o | output | 1 | One-cycle strobe marking a new `sample_o` |

## Verification
Two start rules can release in the same cycle: the minimum spacing from the previous start and the acquisition gap after the last bit clock. The bench sets `CYC_MIN` so that both open on the same cycle. It then pulls `en_i` low for exactly that cycle on several conversions, and also toggles it pseudo-randomly. A behavioural model counts cycles since the previous start and since the last clock fall. It predicts the cycle of every start, bit-clock level and valid strobe, and the bench compares against it every cycle. A one-cycle slip in either gate, or a start taken while `en_i` is low, then shows up as a mismatch on `cnv_o`.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
   // Controller phases of one conversion
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_CNV    = 3'd1,
      PH_WAIT   = 3'd2,
      PH_BURST  = 3'd3,
      PH_SETTLE = 3'd4
   } rd_phase_e;
endpackage

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
   import sar_rd_pkg::*;
#(
   parameter int NBITS         = 16,
   parameter int SYS_PERIOD_NS = 10,
   parameter int CNV_HI        = 2,
   parameter int CYC_MIN       = 10,
   parameter int MSB_WAIT      = 17,
   parameter int CLK_HALF      = 1,
   parameter int LAST_CLK_MAX  = 60,
   parameter int ACQ_MIN       = 4,
   parameter int SYNC_WAIT     = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic cnv_o,
   output logic sclk_o,
   output logic load_o
);
   localparam int TW  = $clog2(CYC_MIN + MSB_WAIT + 2*CLK_HALF*NBITS
                               + SYNC_WAIT + ACQ_MIN + LAST_CLK_MAX + 2);
   localparam int HW  = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
   localparam int PW  = $clog2(NBITS);
   localparam int SW  = (SYNC_WAIT > 1) ? $clog2(SYNC_WAIT) : 1;
   localparam int PCW = $clog2(NBITS + 1);

   localparam logic [TW-1:0] T_CNV = TW'(CNV_HI - 1);
   localparam logic [TW-1:0] T_MSB = TW'(MSB_WAIT - 1);
   localparam logic [TW-1:0] T_CYC = TW'(CYC_MIN - 1);
   localparam logic [TW-1:0] T_ACQ = TW'(ACQ_MIN);
   localparam logic [HW-1:0] H_LIM = HW'(CLK_HALF - 1);
   localparam logic [PW-1:0] P_LIM = PW'(NBITS - 1);
   localparam logic [SW-1:0] S_LIM = SW'(SYNC_WAIT - 1);

   // Elaboration-time checks of the converter limits
   generate
      if (NBITS < 2) begin : g_bad_nbits
         $error("NBITS must be at least 2");
      end
      if (CNV_HI < 1 || CNV_HI*SYS_PERIOD_NS < 10 || CNV_HI*SYS_PERIOD_NS > 40) begin : g_bad_cnv
         $error("start strobe width outside 10..40 ns");
      end
      if (CYC_MIN*SYS_PERIOD_NS < 100) begin : g_bad_cyc
         $error("start spacing below 100 ns");
      end
      if (MSB_WAIT*SYS_PERIOD_NS < 166 || MSB_WAIT <= CNV_HI) begin : g_bad_msb
         $error("first bit clock too early");
      end
      if (ACQ_MIN*SYS_PERIOD_NS < 40) begin : g_bad_acq
         $error("acquisition gap below 40 ns");
      end
      if (CLK_HALF < 1) begin : g_bad_half
         $error("CLK_HALF must be at least 1");
      end
      if (MSB_WAIT + 2*CLK_HALF*(NBITS-1) > LAST_CLK_MAX) begin : g_bad_last
         $error("last bit clock misses its deadline");
      end
      if (SYNC_WAIT < 2) begin : g_bad_sync
         $error("SYNC_WAIT must be at least 2");
      end
   endgenerate

   rd_phase_e       ph_q;
   logic [TW-1:0]   t_q;     // cycles since last start strobe rise
   logic [TW-1:0]   acq_q;   // cycles since last bit clock fall
   logic [HW-1:0]   hc_q;
   logic [PW-1:0]   pc_q;
   logic [SW-1:0]   sc_q;
   logic            cnv_q;
   logic            sclk_q;
   logic            go;

   assign go = en_i && (t_q >= T_CYC) && (acq_q >= T_ACQ);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q   <= PH_IDLE;
         t_q    <= '0;
         acq_q  <= '1;
         hc_q   <= '0;
         pc_q   <= '0;
         sc_q   <= '0;
         cnv_q  <= 1'b0;
         sclk_q <= 1'b0;
      end else begin
         if (t_q != '1)   t_q   <= t_q + 1'b1;
         if (acq_q != '1) acq_q <= acq_q + 1'b1;
         case (ph_q)
            PH_IDLE: begin
               if (go) begin
                  ph_q  <= PH_CNV;
                  cnv_q <= 1'b1;
                  t_q   <= '0;
               end
            end
            PH_CNV: begin
               if (t_q == T_CNV) begin
                  cnv_q <= 1'b0;
                  ph_q  <= PH_WAIT;
               end
            end
            PH_WAIT: begin
               if (t_q == T_MSB) begin
                  sclk_q <= 1'b1;
                  hc_q   <= '0;
                  pc_q   <= '0;
                  ph_q   <= PH_BURST;
               end
            end
            PH_BURST: begin
               if (hc_q == H_LIM) begin
                  hc_q <= '0;
                  if (sclk_q) begin
                     sclk_q <= 1'b0;
                     if (pc_q == P_LIM) begin
                        ph_q  <= PH_SETTLE;
                        sc_q  <= '0;
                        acq_q <= '0;
                     end else begin
                        pc_q <= pc_q + 1'b1;
                     end
                  end else begin
                     sclk_q <= 1'b1;
                  end
               end else begin
                  hc_q <= hc_q + 1'b1;
               end
            end
            PH_SETTLE: begin
               if (sc_q == S_LIM) ph_q <= PH_IDLE;
               else               sc_q <= sc_q + 1'b1;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign cnv_o  = cnv_q;
   assign sclk_o = sclk_q;
   assign load_o = (ph_q == PH_SETTLE) && (sc_q == S_LIM);

   // ---------------- assertions with their own observers ----------------
   localparam logic [TW-1:0]  K_CNV  = TW'(CNV_HI);
   localparam logic [TW-1:0]  K_CYC  = TW'(CYC_MIN);
   localparam logic [TW-1:0]  K_MSB  = TW'(MSB_WAIT);
   localparam logic [TW-1:0]  K_LAST = TW'(LAST_CLK_MAX);
   localparam logic [PCW-1:0] K_N    = PCW'(NBITS);

   logic            cnv_d, sclk_d, rise_now, sclk_rise, sclk_fall;
   logic [TW-1:0]   hi_cnt, gap, quiet;
   logic [PCW-1:0]  pcnt;

   assign rise_now  = cnv_q & ~cnv_d;
   assign sclk_rise = sclk_q & ~sclk_d;
   assign sclk_fall = ~sclk_q & sclk_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnv_d  <= 1'b0;
         sclk_d <= 1'b0;
         hi_cnt <= '0;
         gap    <= '0;
         quiet  <= '1;
         pcnt   <= '0;
      end else begin
         cnv_d  <= cnv_q;
         sclk_d <= sclk_q;
         hi_cnt <= cnv_q ? hi_cnt + 1'b1 : '0;
         if (rise_now)       gap <= TW'(1);
         else if (gap != '1) gap <= gap + 1'b1;
         if (sclk_fall)        quiet <= TW'(1);
         else if (quiet != '1) quiet <= quiet + 1'b1;
         if (rise_now)       pcnt <= '0;
         else if (sclk_rise) pcnt <= pcnt + 1'b1;
      end
   end

   assert_cnv_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnv_d && !cnv_q) |-> (hi_cnt == K_CNV));
   assert_cnv_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_now |-> (gap >= K_CYC));
   assert_first_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sclk_rise && pcnt == '0) |-> (gap == K_MSB));
   assert_clk_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnv_q |-> !sclk_q);
   assert_pulse_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_o |-> (pcnt == K_N));
   assert_last_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sclk_rise |-> (gap <= K_LAST));
   assert_acq_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_now |-> (quiet >= T_ACQ));
endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture #(
   parameter int NBITS    = 16,
   parameter bit DCO_RISE = 1'b1
) (
   input  logic             dco_i,
   input  logic             rst_ni,
   input  logic             d_i,
   output logic [NBITS-1:0] word_o
);
   logic [NBITS-1:0] sh_q;

   // Shift register clocked only by the echoed clock; most significant bit arrives first
   generate
      if (DCO_RISE) begin : g_rise
         always_ff @(posedge dco_i or negedge rst_ni) begin
            if (!rst_ni) sh_q <= '0;
            else         sh_q <= {sh_q[NBITS-2:0], d_i};
         end
      end else begin : g_fall
         always_ff @(negedge dco_i or negedge rst_ni) begin
            if (!rst_ni) sh_q <= '0;
            else         sh_q <= {sh_q[NBITS-2:0], d_i};
         end
      end
   endgenerate

   assign word_o = sh_q;
endmodule

// File: rtl/sar_readout.sv
module sar_readout #(
   parameter int NBITS         = 16,
   parameter int SYS_PERIOD_NS = 10,
   parameter int CNV_HI        = 2,
   parameter int CYC_MIN       = 10,
   parameter int MSB_WAIT      = 17,
   parameter int CLK_HALF      = 1,
   parameter int LAST_CLK_MAX  = 60,
   parameter int ACQ_MIN       = 4,
   parameter int SYNC_WAIT     = 3,
   parameter bit DCO_RISE      = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    en_i,
   output logic                    cnv_o,
   output logic                    sclk_o,
   input  logic                    dco_i,
   input  logic                    d_i,
   output logic signed [NBITS-1:0] sample_o,
   output logic                    valid_o
);
   logic             load;
   logic [NBITS-1:0] word;
   logic [NBITS-1:0] sample_q;
   logic             valid_q;

   sar_rd_seq #(
      .NBITS(NBITS), .SYS_PERIOD_NS(SYS_PERIOD_NS), .CNV_HI(CNV_HI),
      .CYC_MIN(CYC_MIN), .MSB_WAIT(MSB_WAIT), .CLK_HALF(CLK_HALF),
      .LAST_CLK_MAX(LAST_CLK_MAX), .ACQ_MIN(ACQ_MIN), .SYNC_WAIT(SYNC_WAIT)
   ) u_seq (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .cnv_o (cnv_o),
      .sclk_o(sclk_o),
      .load_o(load)
   );

   sar_rd_capture #(.NBITS(NBITS), .DCO_RISE(DCO_RISE)) u_cap (
      .dco_i (dco_i),
      .rst_ni(rst_ni),
      .d_i   (d_i),
      .word_o(word)
   );

   // Transfer into the system domain once the echoed clock has gone quiet
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sample_q <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= load;
         if (load) sample_q <= word;
      end
   end

   assign sample_o = sample_q;
   assign valid_o  = valid_q;

   assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |=> !valid_q);
   assert_sample_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_q |-> $stable(sample_q));
endmodule

// File: tb/sar_readout_bench.sv
module sar_readout_bench;
   localparam int N     = 16;
   localparam int CNVH  = 2;
   localparam int CYC   = 53;   // both start gates open in the same cycle
   localparam int MSB   = 17;
   localparam int HALF  = 1;
   localparam int ACQ   = 4;
   localparam int SYNC  = 3;
   localparam int TEND  = MSB + (2*N-1)*HALF;   // first cycle after last fall
   localparam int TVAL  = TEND + SYNC;
   localparam int NVALS = 64;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
   logic cnv, sclk, valid, d = 1'b0, dco = 1'b0;
   logic signed [N-1:0] sample;

   always #5 clk = ~clk;

   sar_readout #(.NBITS(N), .CNV_HI(CNVH), .CYC_MIN(CYC), .MSB_WAIT(MSB),
                 .CLK_HALF(HALF), .ACQ_MIN(ACQ), .SYNC_WAIT(SYNC)) u_sar_readout (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cnv_o(cnv), .sclk_o(sclk),
      .dco_i(dco), .d_i(d), .sample_o(sample), .valid_o(valid));

   // ---------------- converter model ----------------
   logic [N-1:0] vals [NVALS];
   logic [N-1:0] cw;
   int cidx = -1, bn = 0;

   always @(sclk) dco <= #3 sclk;   // echoed clock, delayed copy

   always @(posedge cnv) begin
      cidx = cidx + 1;
      cw   = vals[cidx % NVALS];
      bn   = N - 1;
      d    = cw[bn];
   end
   always @(negedge dco) begin
      #1;
      if (bn > 0) begin
         bn = bn - 1;
         d  = cw[bn];
      end
   end

   // ---------------- reference model and comparison ----------------
   int n_cmp = 0, n_bad = 0, cyc = 0, wd = 0;
   int start_c = 0, end_c = -100000, conv_n = -1, pulses = 0;
   bit busy = 1'b0, done = 1'b0;
   logic [N-1:0] exp_sample = '0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp = n_cmp + 1;
      if (act != exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
      end
   endtask

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         automatic int  k   = cyc - start_c;
         automatic bit  ecn = busy && (k < CNVH);
         automatic bit  esc = busy && (k >= MSB) && (k < TEND) && (((k - MSB) % (2*HALF)) < HALF);
         automatic bit  evl = busy && (k == TVAL);
         if (esc && busy && k == MSB) pulses = 0;
         if (esc && ((k - MSB) % (2*HALF)) == 0) pulses = pulses + 1;
         chk("R2/R3/R9/R1", "cnv_o", cnv, ecn);        // R4 R6 timing on sclk below
         chk("R4/R5/R6", "sclk_o", sclk, esc);
         chk("R8/R10", "valid_o", valid, evl);
         if (evl) begin
            exp_sample = vals[conv_n % NVALS];
            chk("R5", "pulse count", pulses, N);
            busy  = 1'b0;
            end_c = start_c + TEND;
         end
         chk("R7/R8", "sample_o", sample, $signed(exp_sample));
         // start decision for the next cycle (R3, R9, R10)
         if (!busy && en && (cyc - start_c) >= CYC - 1 && (cyc - end_c) >= ACQ) begin
            start_c = cyc + 1;
            busy    = 1'b1;
            conv_n  = conv_n + 1;
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      wd = wd + 1;
      if (wd > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog expired: actual hang expected completion");
         finish_run();
      end
   end

   initial begin
      automatic logic [31:0] lfsr = 32'h1ACE_B00C;
      vals[0] = 16'h7FFF; vals[1] = 16'h8000; vals[2] = 16'h0000;
      vals[3] = 16'hFFFF; vals[4] = 16'h5A5A; vals[5] = 16'hA5A5;
      vals[6] = 16'h0001; vals[7] = 16'h8001;
      for (int i = 8; i < NVALS; i++) begin
         lfsr    = lfsr * 32'd1664525 + 32'd1013904223;
         vals[i] = lfsr[23:8];
      end

      // R1: outputs quiet during reset
      repeat (3) @(negedge clk);
      chk("R1", "cnv_o in reset", cnv, 0);
      chk("R1", "sclk_o in reset", sclk, 0);
      chk("R1", "valid_o in reset", valid, 0);
      chk("R1", "sample_o in reset", sample, 0);
      en    = 1'b1;   // enabled during reset: first start still waits CYC cycles
      rst_n = 1'b1;

      // continuous conversions
      repeat (8) @(posedge valid);
      // drop enable exactly in the cycle both gates open
      for (int r = 0; r < 6; r++) begin
         @(negedge clk); while (!valid) @(negedge clk);
         @(posedge clk); #1 en = 1'b0;
         repeat (r % 3 + 1) @(posedge clk);
         #1 en = 1'b1;
      end
      // pseudo-random enable pattern
      for (int i = 0; i < 4000; i++) begin
         @(posedge clk); #1;
         lfsr = lfsr * 32'd1664525 + 32'd1013904223;
         if (lfsr[31:29] == 3'b000) en = ~en;
      end
      en = 1'b1;
      repeat (4) @(posedge valid);
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule